// File: doc/BRIEF.md
# Per-Core Low-Power Mode Sequencer

This block steps one processor core into and out of a low-power mode. The core signals that it has executed a wait-for-interrupt instruction. The sequencer then latches the selected mode and performs that mode's entry steps. It idles until a wake interrupt arrives and then undoes the steps in reverse order. The core runs again only after the shared cache side reports that it is ready.

Four modes are supported:

- **Standby** gates the clock only.
- **Retention** gates the clock and also requests a reduced holding voltage.
- **Standalone power-down** removes the core supply without involving any other agent.
- **Power collapse** removes the core supply and also tells a cluster coordinator, through a request/acknowledge pair, that deeper system sleep is allowed.

The power-down modes bring the core back through a warm reset. The power switch, the coordinator and the cache side are all reached through handshake inputs. Each wait on one of those inputs is bounded by a timeout, and an expired timeout sets a sticky error flag.

Top module: `lpm_seq`

## Requirements
- R1: Only a high `wfi_i` sampled while idle starts a sequence. A wake interrupt while idle changes no output.
- R2: `mode_i` is captured on the cycle `wfi_i` is accepted. The encodings are 00 standby, 01 retention, 10 standalone power-down and 11 power collapse. Changes to `mode_i` during a sequence have no effect on that sequence.
- R3: While asleep in standby, the following hold:
  - `clk_gate_o` is 1.
  - `pwr_en_o` is 1.
  - `core_rst_o` is 0.
  - `ret_vreq_o` is 0.
  - `coord_req_o` is 0.
- R4: While asleep in retention, the outputs match standby except that `ret_vreq_o` is 1.
- R5: While asleep in standalone power-down, the following hold:
  - `pwr_en_o` is 0.
  - `core_rst_o` is 1.
  - `coord_req_o` is 0, and it is never raised in this mode.
- R6: In power collapse, `coord_req_o` is raised after the supply is off. The sequencer waits for `coord_ack_i` before sleeping. On exit it drops the request and waits for the acknowledge to fall before power is restored.
- R7: On exit from a power-down mode, `core_rst_o` falls exactly RST_HOLD_CYC+1 cycles after the first cycle in which `pwr_good_i` is high. The extra cycle is the one in which power-good is registered. Non-power modes never assert `core_rst_o`.
- R8: `clk_gate_o` stays 1 while `cache_ready_i` is low at the end of exit. It falls in the cycle after `cache_ready_i` is seen high.
- R9: A wake interrupt that arrives during entry steps is latched. After entry, the sequence goes straight to exit without a second interrupt.
- R10: A handshake wait that lasts TMO_CYC cycles sets `timeout_err_o` and lets the sequence advance. The flag stays set until reset and stays 0 while no wait has expired.
- R11: After reset, the outputs are as follows:
  - `clk_gate_o` is 0.
  - `pwr_en_o` is 1.
  - `core_rst_o` is 0.
  - `ret_vreq_o` is 0.
  - `coord_req_o` is 0.
  - `timeout_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Core executed wait-for-interrupt |
| mode_i | input | 2 | Selected low-power mode |
| wake_irq_i | input | 1 | Wake interrupt |
| pwr_good_i | input | 1 | Core supply is up |
| coord_ack_i | input | 1 | Cluster coordinator acknowledge |
| cache_ready_i | input | 1 | Cache side ready for core to resume |
| clk_gate_o | output | 1 | Gate the core clock |
| ret_vreq_o | output | 1 | Request retention voltage |
| pwr_en_o | output | 1 | Core power-switch enable |
| core_rst_o | output | 1 | Core reset |
| coord_req_o | output | 1 | Permit deeper system sleep |
| timeout_err_o | output | 1 | Sticky handshake-timeout flag |

## Verification
The hardest case to reach is a wake interrupt that lands during the entry steps. Once the latch takes it, the sleep state looks the same at the ports as a machine still waiting for a second interrupt. The stimulus pulses the interrupt on the cycle right after the WFI is accepted, for every mode, and sends no further interrupt. It then shows the exit finished by raising cache-ready once and watching the clock gate drop. Timeouts are provoked by holding power-good stuck high while the sequencer tries to remove power.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_STBY = 2'b00,
        MODE_RET  = 2'b01,
        MODE_SPD  = 2'b10,
        MODE_COL  = 2'b11
    } lpm_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GATE,
        ST_PWR_OFF,
        ST_COORD_REQ,
        ST_SLEEP,
        ST_COORD_REL,
        ST_PWR_ON,
        ST_RST_HOLD,
        ST_CACHE_WAIT
    } lpm_state_e;

    typedef struct packed {
        lpm_state_e state;
        lpm_mode_e  mode;
        logic       err;
    } lpm_regs_t;

endpackage

// File: rtl/lpm_step_cnt.sv
module lpm_step_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i)
            cnt_d = '0;
        else if (cnt_q == {W{1'b1}})
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/lpm_wake_latch.sv
module lpm_wake_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_i)      pend_d = 1'b0;
        else if (set_i) pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int TMO_CYC      = 256,
    parameter int RST_HOLD_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_i,
    input  logic [1:0] mode_i,
    input  logic       wake_irq_i,
    input  logic       pwr_good_i,
    input  logic       coord_ack_i,
    input  logic       cache_ready_i,
    output logic       clk_gate_o,
    output logic       ret_vreq_o,
    output logic       pwr_en_o,
    output logic       core_rst_o,
    output logic       coord_req_o,
    output logic       timeout_err_o
);
    localparam int CNT_MAX = (TMO_CYC > RST_HOLD_CYC) ? TMO_CYC : RST_HOLD_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    lpm_regs_t r_d, r_q;

    logic [CNT_W-1:0] cnt;
    logic             wake_pend;
    logic             tmo_hit, hold_done, is_pwr, woke;
    logic             wait_ok, in_wait, in_entry;

    lpm_step_cnt #(.W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (r_d.state != r_q.state),
        .cnt_o (cnt)
    );

    assign in_entry = (r_q.state == ST_GATE) || (r_q.state == ST_PWR_OFF) ||
                      (r_q.state == ST_COORD_REQ);

    lpm_wake_latch wake_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wake_irq_i && in_entry),
        .clr_i  (r_q.state == ST_SLEEP),
        .pend_o (wake_pend)
    );

    assign tmo_hit   = (cnt == CNT_W'(TMO_CYC - 1));
    assign hold_done = (cnt == CNT_W'(RST_HOLD_CYC - 1));
    assign is_pwr    = r_q.mode[1];
    assign woke      = wake_irq_i || wake_pend;

    // Handshake condition awaited in each bounded wait state
    always_comb begin
        in_wait = 1'b1;
        wait_ok = 1'b0;
        case (r_q.state)
            ST_PWR_OFF:    wait_ok = !pwr_good_i;
            ST_COORD_REQ:  wait_ok = coord_ack_i;
            ST_COORD_REL:  wait_ok = !coord_ack_i;
            ST_PWR_ON:     wait_ok = pwr_good_i;
            ST_CACHE_WAIT: wait_ok = cache_ready_i;
            default:       in_wait = 1'b0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (in_wait && tmo_hit && !wait_ok)
            r_d.err = 1'b1;
        case (r_q.state)
            ST_IDLE: begin
                if (wfi_i) begin
                    r_d.mode  = lpm_mode_e'(mode_i);
                    r_d.state = ST_GATE;
                end
            end
            ST_GATE:
                r_d.state = is_pwr ? ST_PWR_OFF : ST_SLEEP;
            ST_PWR_OFF:
                if (wait_ok || tmo_hit)
                    r_d.state = (r_q.mode == MODE_COL) ? ST_COORD_REQ : ST_SLEEP;
            ST_COORD_REQ:
                if (wait_ok || tmo_hit) r_d.state = ST_SLEEP;
            ST_SLEEP:
                if (woke) begin
                    if (!is_pwr)                     r_d.state = ST_CACHE_WAIT;
                    else if (r_q.mode == MODE_COL)   r_d.state = ST_COORD_REL;
                    else                             r_d.state = ST_PWR_ON;
                end
            ST_COORD_REL:
                if (wait_ok || tmo_hit) r_d.state = ST_PWR_ON;
            ST_PWR_ON:
                if (wait_ok || tmo_hit) r_d.state = ST_RST_HOLD;
            ST_RST_HOLD:
                if (hold_done) r_d.state = ST_CACHE_WAIT;
            ST_CACHE_WAIT:
                if (wait_ok || tmo_hit) r_d.state = ST_IDLE;
            default:
                r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.mode  <= MODE_STBY;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // Output decode
    logic supply_off, rst_span;
    assign supply_off = is_pwr && ((r_q.state == ST_PWR_OFF) || (r_q.state == ST_COORD_REQ) ||
                                   (r_q.state == ST_SLEEP)   || (r_q.state == ST_COORD_REL));
    assign rst_span   = is_pwr && (supply_off || (r_q.state == ST_PWR_ON) ||
                                   (r_q.state == ST_RST_HOLD));

    assign clk_gate_o    = (r_q.state != ST_IDLE);
    assign ret_vreq_o    = (r_q.mode == MODE_RET) && (r_q.state == ST_SLEEP);
    assign pwr_en_o      = !supply_off;
    assign core_rst_o    = rst_span;
    assign coord_req_o   = (r_q.mode == MODE_COL) &&
                           ((r_q.state == ST_COORD_REQ) || (r_q.state == ST_SLEEP));
    assign timeout_err_o = r_q.err;

    AST_START_ON_WFI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_gate_o) |-> $past(wfi_i)); // R1
    AST_UNPOWERED_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en_o |-> (clk_gate_o && core_rst_o)); // R5
    AST_REQ_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        coord_req_o |-> !pwr_en_o); // R6
    AST_RELEASE_AFTER_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_gate_o) |-> ($past(cache_ready_i) || timeout_err_o)); // R8
    AST_RELEASE_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_gate_o) |-> !core_rst_o); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o |=> timeout_err_o); // R10
endmodule

// File: tb/lpm_seq_tb_top.sv
`timescale 1ns/100ps
module lpm_seq_tb_top;
    localparam int TMO = 256;
    localparam int RST = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi = 1'b0, irq = 1'b0, cache_rdy = 1'b0, force_pg = 1'b0;
    logic [1:0] mode = 2'b00;
    logic pg_m = 1'b1, ack_m = 1'b0;
    logic clk_gate, ret_vreq, pwr_en, core_rst, coord_req, tmo_err;
    int errors = 0, checks = 0;

    always #2.5 clk = ~clk;

    lpm_seq #(.TMO_CYC(TMO), .RST_HOLD_CYC(RST)) dut_i (
        .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .mode_i(mode), .wake_irq_i(irq),
        .pwr_good_i(pg_m | force_pg), .coord_ack_i(ack_m), .cache_ready_i(cache_rdy),
        .clk_gate_o(clk_gate), .ret_vreq_o(ret_vreq), .pwr_en_o(pwr_en),
        .core_rst_o(core_rst), .coord_req_o(coord_req), .timeout_err_o(tmo_err)
    );

    // Power switch and coordinator models: one cycle of latency each
    always @(posedge clk) begin
        pg_m  <= pwr_en;
        ack_m <= coord_req;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_reset_vals();
        check("R11 clk_gate", clk_gate, 0);
        check("R11 pwr_en", pwr_en, 1);
        check("R11 core_rst", core_rst, 0);
        check("R11 ret_vreq", ret_vreq, 0);
        check("R11 coord_req", coord_req, 0);
        check("R11 timeout_err", tmo_err, 0);
    endtask

    task automatic run_mode(input logic [1:0] m, input bit early);
        int rcnt = 0;
        @(negedge clk); mode = m; wfi = 1'b1;
        @(negedge clk); wfi = 1'b0; mode = ~m; irq = early;
        @(negedge clk); irq = 1'b0;
        if (!early) begin
            repeat (18) @(negedge clk);
            // R2: sleep outputs follow the captured mode, not the changed input
            check("R3 R4 R5 R6 asleep clk_gate", clk_gate, 1);
            check("R3 R5 asleep pwr_en", pwr_en, m[1] ? 0 : 1);
            check("R3 R5 asleep core_rst", core_rst, m[1] ? 1 : 0);
            check("R4 asleep ret_vreq", ret_vreq, (m == 2'b01) ? 1 : 0);
            check("R5 R6 asleep coord_req", coord_req, (m == 2'b11) ? 1 : 0);
            irq = 1'b1;
            @(negedge clk); irq = 1'b0;
            for (int i = 0; i < 38; i++) begin
                if ((pg_m | force_pg) && core_rst) rcnt++;
                @(negedge clk);
            end
            check("R7 reset hold cycles", rcnt, m[1] ? RST + 1 : 0);
        end else begin
            repeat (38) @(negedge clk);
            // R9: latched interrupt completed the exit with no second interrupt
            check("R9 pwr_en restored", pwr_en, 1);
            check("R9 core_rst released", core_rst, 0);
            check("R9 ret_vreq low", ret_vreq, 0);
            check("R9 coord_req low", coord_req, 0);
        end
        check("R8 gated before cache ready", clk_gate, 1);
        cache_rdy = 1'b1;
        @(negedge clk); cache_rdy = 1'b0;
        check("R8 released after cache ready", clk_gate, 0);
        check("R10 no timeout", tmo_err, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_vals();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_vals();

        // R1: interrupt while idle is ignored
        irq = 1'b1;
        @(negedge clk); irq = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 idle irq ignored clk_gate", clk_gate, 0);
        check("R1 idle irq ignored pwr_en", pwr_en, 1);

        for (int e = 0; e < 2; e++)
            for (int m = 0; m < 4; m++)
                run_mode(2'(m), e[0]);

        // R10: supply never drops -> power-off wait times out
        force_pg = 1'b1;
        @(negedge clk); mode = 2'b10; wfi = 1'b1;
        @(negedge clk); wfi = 1'b0;
        repeat (100) @(negedge clk);
        check("R10 no error before timeout", tmo_err, 0);
        check("R5 supply removed while waiting", pwr_en, 0);
        repeat (200) @(negedge clk);
        check("R10 error after timeout", tmo_err, 1);
        irq = 1'b1;
        @(negedge clk); irq = 1'b0;
        repeat (40) @(negedge clk);
        cache_rdy = 1'b1;
        @(negedge clk); cache_rdy = 1'b0;
        check("R10 sequence advanced to release", clk_gate, 0);
        repeat (5) @(negedge clk);
        check("R10 error sticky", tmo_err, 1);
        force_pg = 1'b0;

        rst_n = 1'b0;
        @(negedge clk);
        check_reset_vals();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule